// File: doc/BRIEF.md
# SIMD Coprocessor Issue Queue with Fixed-Latency Pipeline

This block sits beside an in-order integer core and receives at most one instruction per clock from it. Integer work passes straight through. Vector (SIMD) operations are written into a bounded in-order queue. From the queue they enter a coprocessor pipeline that can begin an operation only every few cycles, and each operation returns its result a fixed number of cycles after it begins. The block raises a combinational stall to the integer side in two cases: when the queue has no room, and when a move from a vector register to an integer register needs a value that has not yet been written back.

The payload is not interpreted. Each operation carries a destination register, two source registers and an opaque tag. The tag and destination come out on the write-back port. A per-register count of outstanding writers drives the read-back interlock. A match against the destinations still in the pipeline stops the queue head from starting while one of its sources is being computed. Default sizing: 6 queue slots, a latency of 6, an initiation interval of 2, and 8 vector registers.

Top module: `simd_issue_top`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears every pending register and drains the pipeline. In the first cycle after reset, `wb_valid` is low and nothing stalls.
- R2: `stall` is never high when `in_valid` is low or when `in_kind` is 0 (integer) or 3 (no coprocessor effect).
- R3: With `in_kind` = 1 (SIMD), the queue accepts up to 6 entries. A SIMD instruction that arrives at a full queue stalls in every cycle in which no queued operation starts.
- R4: If the queue is full and an operation starts in the same cycle, a SIMD instruction arriving in that cycle is accepted without a stall, and the occupancy stays at 6.
- R5: An operation that starts in cycle s is written back in cycle s+6. A SIMD instruction accepted in cycle c while the block is idle is written back in cycle c+7.
- R6: Two operations never start less than 2 cycles apart. A backlog of independent operations is written back once every 2 cycles.
- R7: An operation does not start while either source register is the destination of an operation in pipeline stages 0 to 4. It may start in the cycle in which that source is written back.
- R8: Operations start and write back in queue order. An independent operation queued behind a blocked head waits for the head.
- R9: With `in_kind` = 2 (read-back), register `in_src_a` is read. The read-back stalls while that register has a result outstanding and is released in the write-back cycle of its last outstanding writer. A read-back of a register with no outstanding result does not stall.
- R10: The write-back port returns the tag and the destination register of the operation.
- R11: A reset while operations are queued or in flight discards them. No write-back follows, and their destinations stop stalling read-backs.
- R12: When several queued or in-flight operations target the same register, a read-back of it waits for the write-back of the youngest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_kind | input | 2 | 0 integer, 1 SIMD operation, 2 read-back, 3 no coprocessor effect |
| in_dst | input | $clog2(NREG) | Destination vector register of a SIMD operation |
| in_src_a | input | $clog2(NREG) | First source; the register read by a read-back |
| in_src_b | input | $clog2(NREG) | Second source of a SIMD operation |
| in_tag | input | TAGW | Opaque payload carried to write-back |
| stall | output | 1 | Integer side must hold the presented instruction |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_reg | output | $clog2(NREG) | Destination register of the result |
| wb_tag | output | TAGW | Tag of the result |

## Verification
The hardest case to reach from the ports is a queue that is full while its head is held by a dependency, since the initiation interval normally drains the queue faster than a blocked head can fill it. The bench builds it with one producer, one consumer of that producer, and a run of operations that all depend on the consumer. This pins the head for five cycles at full occupancy. In that window it tests integer pass-through, a stalled SIMD push, and the push-with-pop cycle just before it. Sweeps over the gap between a producer and its consumer or read-back cover every distance on both sides of the latency.

// File: rtl/simd_cop_pkg.sv
package simd_cop_pkg;

  typedef enum logic [1:0] {
    KIND_INT  = 2'd0,
    KIND_SIMD = 2'd1,
    KIND_RDBK = 2'd2,
    KIND_NOP  = 2'd3
  } kind_e;

  // Circular pointer advance for a ring of n slots.
  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of optional push and pop.
  function automatic int unsigned occ_after(int unsigned occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Cycles remaining before the pipeline may begin another operation.
  function automatic int unsigned cool_after(int unsigned cool, logic start, int unsigned ii);
    if (start) return ii - 1;
    if (cool != 0) return cool - 1;
    return 0;
  endfunction

endpackage

// File: rtl/simd_cop_fifo.sv
module simd_cop_fifo
  import simd_cop_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int W     = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      occ <= CW'(occ_after(int'(occ), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= din;
  end

  assign dout  = slot[rd_ptr];
  assign empty = (occ == '0);
  assign full  = (occ == CW'(DEPTH));
endmodule

// File: rtl/simd_cop_scoreboard.sv
module simd_cop_scoreboard #(
  parameter int NREG = 8,
  parameter int CNTW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mark_en,
  input  logic [$clog2(NREG)-1:0] mark_idx,
  input  logic                    done_en,
  input  logic [$clog2(NREG)-1:0] done_idx,
  input  logic [$clog2(NREG)-1:0] ask_idx,
  output logic                    ask_busy,
  output logic                    ask_free
);
  localparam int RW = $clog2(NREG);

  logic [CNTW-1:0] outstanding [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic inc;
    logic dec;
    assign inc = mark_en && (mark_idx == RW'(r));
    assign dec = done_en && (done_idx == RW'(r));
    always_ff @(posedge clk) begin
      if (rst)              outstanding[r] <= '0;
      else if (inc && !dec) outstanding[r] <= outstanding[r] + 1'b1;
      else if (dec && !inc) outstanding[r] <= outstanding[r] - 1'b1;
    end
  end

  assign ask_busy = (outstanding[ask_idx] != '0);
  // The last outstanding writer of the asked register retires this cycle.
  assign ask_free = done_en && (done_idx == ask_idx) && (outstanding[ask_idx] == CNTW'(1));
endmodule

// File: rtl/simd_cop_pipe.sv
module simd_cop_pipe
  import simd_cop_pkg::*;
#(
  parameter int LAT  = 6,
  parameter int II   = 2,
  parameter int RW   = 3,
  parameter int TW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] start_dst,
  input  logic [TW-1:0] start_tag,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  output logic          ready,
  output logic          hazard,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [TW-1:0] wb_tag
);
  localparam int CLW = $clog2(II + 1);

  logic [LAT-1:0] stg_v;
  logic [RW-1:0]  stg_d [LAT];
  logic [TW-1:0]  stg_t [LAT];
  logic [CLW-1:0] cool;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= '0;
      cool  <= '0;
    end else begin
      stg_v <= {stg_v[LAT-2:0], start};
      cool  <= CLW'(cool_after(int'(cool), start, II));
    end
  end

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        stg_d[0] <= start_dst;
        stg_t[0] <= start_tag;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        stg_d[s] <= stg_d[s-1];
        stg_t[s] <= stg_t[s-1];
      end
    end
  end

  // A source still being computed in stages 0..LAT-2 blocks the start;
  // the last stage is the write-back cycle, where starting is allowed.
  always_comb begin
    hazard = 1'b0;
    for (int s = 0; s < LAT - 1; s++) begin
      if (stg_v[s] && ((stg_d[s] == src_a) || (stg_d[s] == src_b))) hazard = 1'b1;
    end
  end

  assign ready    = (cool == '0);
  assign wb_valid = stg_v[LAT-1];
  assign wb_reg   = stg_d[LAT-1];
  assign wb_tag   = stg_t[LAT-1];
endmodule

// File: rtl/simd_issue_top.sv
module simd_issue_top
  import simd_cop_pkg::*;
#(
  parameter int QDEPTH = 6,
  parameter int LAT    = 6,
  parameter int II     = 2,
  parameter int NREG   = 8,
  parameter int TAGW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_kind,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src_a,
  input  logic [$clog2(NREG)-1:0] in_src_b,
  input  logic [TAGW-1:0]         in_tag,
  output logic                    stall,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [TAGW-1:0]         wb_tag
);
  localparam int RW   = $clog2(NREG);
  localparam int EW   = TAGW + 3 * RW;
  localparam int CNTW = $clog2(QDEPTH + LAT + 1);

  kind_e kind;
  logic  is_simd;
  logic  is_rdbk;
  logic  q_push;
  logic  q_pop;
  logic  q_full;
  logic  q_empty;
  logic  head_ready;
  logic  head_hazard;
  logic  rb_busy;
  logic  rb_free;
  logic  rb_wait;

  logic [EW-1:0]   q_in;
  logic [EW-1:0]   q_head;
  logic [TAGW-1:0] head_tag;
  logic [RW-1:0]   head_dst;
  logic [RW-1:0]   head_sa;
  logic [RW-1:0]   head_sb;

  assign kind    = kind_e'(in_kind);
  assign is_simd = in_valid && (kind == KIND_SIMD);
  assign is_rdbk = in_valid && (kind == KIND_RDBK);

  assign q_in = {in_tag, in_dst, in_src_a, in_src_b};
  assign {head_tag, head_dst, head_sa, head_sb} = q_head;

  assign q_pop   = !q_empty && head_ready && !head_hazard;
  assign rb_wait = rb_busy && !rb_free;
  assign stall   = (is_simd && q_full && !q_pop) || (is_rdbk && rb_wait);
  assign q_push  = is_simd && !stall;

  simd_cop_fifo #(.DEPTH(QDEPTH), .W(EW)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .din   (q_in),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  simd_cop_pipe #(.LAT(LAT), .II(II), .RW(RW), .TW(TAGW)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .start     (q_pop),
    .start_dst (head_dst),
    .start_tag (head_tag),
    .src_a     (head_sa),
    .src_b     (head_sb),
    .ready     (head_ready),
    .hazard    (head_hazard),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .wb_tag    (wb_tag)
  );

  simd_cop_scoreboard #(.NREG(NREG), .CNTW(CNTW)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .mark_en  (q_push),
    .mark_idx (in_dst),
    .done_en  (wb_valid),
    .done_idx (wb_reg),
    .ask_idx  (in_src_a),
    .ask_busy (rb_busy),
    .ask_free (rb_free)
  );
endmodule

// File: rtl/simd_cop_checker.sv
module simd_cop_checker #(
  parameter int LAT = 6,
  parameter int II  = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] in_kind,
  input logic       stall,
  input logic       wb_valid,
  input logic       q_push,
  input logic       q_pop,
  input logic       q_full,
  input logic       q_empty
);
  logic [LAT-1:0] pop_hist;
  logic [7:0]     since_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_hist  <= '0;
      since_pop <= 8'(II);
    end else begin
      pop_hist  <= {pop_hist[LAT-2:0], q_pop};
      since_pop <= q_pop ? 8'd0 : ((since_pop == 8'hFF) ? since_pop : since_pop + 8'd1);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q_empty && !wb_valid));

  assert_int_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_kind == 2'd0 || in_kind == 2'd3) |-> !stall);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (q_full && !q_pop) |-> !q_push);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    q_empty |-> !q_pop);

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    wb_valid == pop_hist[LAT-1]);

  assert_interval_R6: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> (since_pop >= 8'(II - 1)));
endmodule

bind simd_issue_top simd_cop_checker #(.LAT(LAT), .II(II)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_kind  (in_kind),
  .stall    (stall),
  .wb_valid (wb_valid),
  .q_push   (q_push),
  .q_pop    (q_pop),
  .q_full   (q_full),
  .q_empty  (q_empty)
);

// File: tb/simd_issue_top_tb.sv
module simd_issue_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [2:0] in_dst = 3'd0;
  logic [2:0] in_src_a = 3'd0;
  logic [2:0] in_src_b = 3'd0;
  logic [7:0] in_tag = 8'd0;
  logic       stall;
  logic       wb_valid;
  logic [2:0] wb_reg;
  logic [7:0] wb_tag;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  int wb_n = 0;
  int wb_c [256];
  int wb_t [256];
  int wb_r [256];
  bit done = 0;

  always #5 clk = ~clk;

  simd_issue_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_tag(in_tag),
    .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_tag(wb_tag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wb_valid && wb_n < 256) begin
      wb_c[wb_n] = cyc;
      wb_t[wb_n] = int'(wb_tag);
      wb_r[wb_n] = int'(wb_reg);
      wb_n = wb_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wb_cycle_of(input int tag);
    for (int i = 0; i < wb_n; i++) if (wb_t[i] == tag) return wb_c[i];
    return -1;
  endfunction

  function automatic int wb_reg_of(input int tag);
    for (int i = 0; i < wb_n; i++) if (wb_t[i] == tag) return wb_r[i];
    return -1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected accept offset of the k-th op of a back-to-back stream
  // (6 slots, one start every 2 cycles).
  function automatic int stream_accept(input int k);
    return (k < 12) ? k : 13 + 2 * (k - 12);
  endfunction

  task automatic send(input int kind, input int d, input int a, input int b, input int tg,
                      output int pres, output int acc);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_kind  = 2'(kind);
    in_dst   = 3'(d);
    in_src_a = 3'(a);
    in_src_b = 3'(b);
    in_tag   = 8'(tg);
    pres     = cyc;
    forever begin
      @(negedge clk);
      if (!stall) begin
        acc = cyc;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1 rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 rst = 1'b0;
    wb_n = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int p, a0, a1, a2, a3;
    int acc [14];

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(wb_valid == 1'b0, "R1 wb_valid after reset", int'(wb_valid), 0);
    send(2, 0, 0, 0, 0, p, a0);
    chk(a0 == p, "R1 read-back after reset not stalled", a0 - p, 0);
    send(1, 0, 6, 7, 1, p, a0);
    chk(a0 == p, "R1 SIMD push after reset not stalled", a0 - p, 0);
    idle(10);

    // R5 R7 R10: producer/consumer gap sweep
    for (int g = 1; g <= 8; g++) begin
      do_reset();
      send(1, 1, 6, 7, 10, p, a0);
      idle(g - 1);
      send(1, 2, 1, 5, 11, p, a1);
      idle(20);
      chk(wb_cycle_of(10) == a0 + 7, "R5 latency", wb_cycle_of(10) - a0, 7);
      chk(wb_cycle_of(11) == imax(a1 + 1, a0 + 7) + 6, "R7 RAW start",
          wb_cycle_of(11), imax(a1 + 1, a0 + 7) + 6);
      chk(wb_reg_of(11) == 2, "R10 write-back register", wb_reg_of(11), 2);
    end

    // R3 R4 R6 R10: back-to-back stream of 14 independent ops
    do_reset();
    for (int k = 0; k < 14; k++) send(1, k % 4, 4, 5, 32 + k, p, acc[k]);
    idle(40);
    for (int k = 0; k < 14; k++) begin
      chk(acc[k] - acc[0] == stream_accept(k), "R3 stream accept cycle",
          acc[k] - acc[0], stream_accept(k));
      chk(wb_cycle_of(32 + k) - acc[0] == 7 + 2 * k, "R6 stream write-back cycle",
          wb_cycle_of(32 + k) - acc[0], 7 + 2 * k);
      chk(wb_reg_of(32 + k) == k % 4, "R10 stream register", wb_reg_of(32 + k), k % 4);
    end

    // R8: independent op waits behind a blocked head
    do_reset();
    send(1, 1, 6, 7, 60, p, a0);
    send(1, 2, 1, 1, 61, p, a1);
    send(1, 3, 6, 7, 62, p, a2);
    idle(30);
    chk(wb_cycle_of(61) == a0 + 13, "R8 blocked head write-back", wb_cycle_of(61) - a0, 13);
    chk(wb_cycle_of(62) == a0 + 15, "R8 follower waits", wb_cycle_of(62) - a0, 15);

    // R9: read-back gap sweep on a pending register
    for (int g = 1; g <= 9; g++) begin
      do_reset();
      send(1, 3, 6, 7, 70, p, a0);
      idle(g - 1);
      send(2, 0, 3, 0, 0, p, a1);
      idle(1);
      chk(a1 == imax(a0 + g, a0 + 7), "R9 read-back release cycle",
          a1 - a0, imax(g, 7));
    end
    send(2, 0, 5, 0, 0, p, a1);
    chk(a1 == p, "R9 read-back of idle register", a1 - p, 0);
    idle(5);

    // R12: two writers to one register
    do_reset();
    send(1, 3, 6, 7, 80, p, a0);
    send(1, 3, 6, 7, 81, p, a1);
    send(2, 0, 3, 0, 0, p, a2);
    idle(20);
    chk(a2 == a0 + 9, "R12 read-back waits for youngest writer", a2 - a0, 9);
    chk(wb_cycle_of(81) == a0 + 9, "R12 second writer write-back", wb_cycle_of(81) - a0, 9);

    // R2 R3 R4: full queue pinned by a dependency chain
    do_reset();
    send(1, 1, 6, 7, 100, p, a0);
    send(1, 2, 1, 1, 101, p, a1);
    for (int k = 0; k < 5; k++) send(1, 3, 2, 2, 102 + k, p, a2);
    send(1, 3, 2, 2, 107, p, a2);
    chk(a2 == p && a2 == a0 + 7, "R4 push while full with start", a2 - a0, 7);
    send(0, 0, 0, 0, 0, p, a3);
    chk(a3 == p, "R2 integer passes full queue", a3 - p, 0);
    send(1, 3, 2, 2, 108, p, a3);
    chk(a3 == a0 + 13, "R3 SIMD held on full queue", a3 - a0, 13);
    chk(p == a0 + 9, "R3 presentation cycle", p - a0, 9);
    idle(40);
    chk(wb_n == 9, "R3 all queued ops complete", wb_n, 9);

    // R11: reset while ops are in flight
    do_reset();
    send(1, 1, 6, 7, 120, p, a0);
    send(1, 2, 6, 7, 121, p, a0);
    send(1, 3, 6, 7, 122, p, a0);
    idle(2);
    do_reset();
    idle(12);
    chk(wb_n == 0, "R11 no write-back after reset", wb_n, 0);
    send(2, 0, 1, 0, 0, p, a1);
    chk(a1 == p, "R11 read-back after reset not stalled", a1 - p, 0);
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule